// File: doc/BRIEF.md
# SD Card SPI-Mode Command Responder

This block stands in for an SD card that is talking in SPI mode, but it is seen through a parallel byte port instead of a serial shifter. The host writes bytes to a data port and reads bytes back from it. It also writes an active-low select register. Six-byte command frames are collected, decoded against a fixed command subset, and answered with R1-style status bytes. Single-block reads and writes reach an internal byte store. The store is addressed by a 32-bit byte offset, so blocks need not be aligned.

The output side (command collection and write-data intake) and the input side (response delivery) are separate state machines. A new command can therefore be framed while an older response is still waiting. Executing that new command replaces the old response. An application-command prefix marks the next command as application-specific. Writes end with a one-byte data-response token.

Each read strobe consumes one byte. The byte on `rsp_byte` is the one the strobe will consume, and it is valid before the strobe is given. CRC values are never checked. The only part of the final frame byte that is used is its bit 0.

Top module: `sd_spi_responder`

## Requirements
- R1: While the select register holds 1 (deselected), `rsp_byte` is 0xFF, read strobes consume nothing and data writes have no effect. The select register is 1 after reset.
- R2: Writing 1 to the select register returns both state machines to idle, discards any pending response and clears the application flag. A half-sent frame and a pending application prefix are both lost.
- R3: In the idle output state, only a byte of the form 01xxxxxx starts a frame, and its low six bits give the command index. Bytes 2 to 5 are the argument, most significant first, and byte 6 ends the frame. The command executes on the next data write after byte 6, and the value of that write is ignored. Until then, reads return 0xFF.
- R4: The base status is 0x00 when bit 0 of frame byte 6 is 1, and 0x04 when it is 0.
- R5: Command 55 answers base OR 0x01 and sets the application flag. The next executed command is treated as application-specific and clears the flag, so an application-specific 55 or 17 is illegal.
- R6: Command 0 answers base OR 0x01, and command 8 answers base OR 0x04. Command 13 answers 0x00 then 0x00. Application command 41 answers base. Every other index answers base OR 0x04.
- R7: Command 17 with the block in range answers base, 0xFF, 0xFF, 0xFE, then 512 store bytes starting at the argument byte address, then 0xFF, 0xFF. That is 518 bytes in all.
- R8: Command 17 whose block does not lie entirely inside the store (address + 512 > capacity, with no wrap) answers one byte, base OR 0x04. An address of capacity − 512 is accepted.
- R9: Command 24 answers base, and the block then ignores written bytes until one equals 0xFE. It stores the next 512 written bytes from the argument address. The write after those 512 bytes answers 0x05.
- R10: Command 24 with an out-of-range block accepts the same byte sequence, leaves the store unchanged, and answers 0x0B at the final write.
- R11: After the last byte of a response has been consumed, reads return 0xFF until another response is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_wr | input | 1 | Write strobe for the select register |
| sel_val | input | 1 | Value for the select register (1 = deselected) |
| cmd_wr | input | 1 | Data-port write strobe |
| cmd_byte | input | 8 | Byte written to the data port |
| rsp_rd | input | 1 | Data-port read strobe, consumes the byte shown |
| rsp_byte | output | 8 | Byte the next read returns |

## Verification
The hardest situation to reach is the command-24 failure path, where a fully framed write to an out-of-range block must leave the store untouched. Proving "untouched" needs known content at the overlapping addresses. The bench first fills the whole store through normal command-24 writes, which it mirrors in its own model. It then attempts a write at capacity − 511 with different data and reads back the top block through command 17. Unaligned reads across block edges, and an address that would wrap past 2^32, exercise the range check from both sides.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

    localparam logic [9:0] BLK_LEN   = 10'd512;
    localparam logic [9:0] RD_LEN    = 10'd518;
    localparam logic [9:0] DATA_END  = 10'd516;
    localparam logic [2:0] FRAME_LEN = 3'd6;

    localparam logic [7:0] FILL      = 8'hFF;
    localparam logic [7:0] TOK_START = 8'hFE;
    localparam logic [7:0] WR_ACCEPT = 8'h05;
    localparam logic [7:0] WR_REJECT = 8'h0B;
    localparam logic [7:0] ST_IDLE   = 8'h01;
    localparam logic [7:0] ST_ILLEGAL = 8'h04;

    // 7-bit command code: bit 6 marks an application-specific command
    localparam logic [6:0] OP_RESET   = 7'd0;
    localparam logic [6:0] OP_IFCOND  = 7'd8;
    localparam logic [6:0] OP_STATUS  = 7'd13;
    localparam logic [6:0] OP_RDBLK   = 7'd17;
    localparam logic [6:0] OP_WRBLK   = 7'd24;
    localparam logic [6:0] OP_APPPFX  = 7'd55;
    localparam logic [6:0] OP_APPINIT = 7'd41 + 7'h40;

    typedef enum logic [1:0] {OS_IDLE, OS_CMD, OS_SBLK, OS_WBLK} ostate_t;
    typedef enum logic {RK_BYTES, RK_BLOCK} rkind_t;

    typedef struct packed {
        rkind_t     kind;
        logic [7:0] b0;
        logic [7:0] b1;
        logic [9:0] len;
    } rsp_desc_t;

    function automatic logic blk_fits(logic [31:0] addr, logic [32:0] cap);
        return ({1'b0, addr} + 33'd512) <= cap;
    endfunction

    function automatic rsp_desc_t one_byte(logic [7:0] v);
        return '{kind: RK_BYTES, b0: v, b1: 8'h00, len: 10'd1};
    endfunction

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
    import sdr_pkg::*;
(
    input  logic [6:0] op,
    input  logic       end_bit,
    input  logic       rd_fits,
    output rsp_desc_t  desc,
    output ostate_t    nxt,
    output logic       set_app
);
    logic [7:0] base;

    always_comb begin
        base    = end_bit ? 8'h00 : ST_ILLEGAL;
        nxt     = OS_IDLE;
        set_app = 1'b0;
        desc    = one_byte(base | ST_ILLEGAL);
        case (op)
            OP_RESET:   desc = one_byte(base | ST_IDLE);
            OP_IFCOND:  desc = one_byte(base | ST_ILLEGAL);
            OP_STATUS:  desc = '{kind: RK_BYTES, b0: 8'h00, b1: 8'h00, len: 10'd2};
            OP_RDBLK: begin
                if (rd_fits) desc = '{kind: RK_BLOCK, b0: base, b1: FILL, len: RD_LEN};
                else         desc = one_byte(base | ST_ILLEGAL);
            end
            OP_WRBLK: begin
                desc = one_byte(base);
                nxt  = OS_SBLK;
            end
            OP_APPPFX: begin
                desc    = one_byte(base | ST_IDLE);
                set_app = 1'b1;
            end
            OP_APPINIT: desc = one_byte(base);
            default:    desc = one_byte(base | ST_ILLEGAL);
        endcase
    end
endmodule

// File: rtl/sdr_resp_seq.sv
module sdr_resp_seq
    import sdr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       load,
    input  rsp_desc_t  desc,
    input  logic       pop,
    input  logic [7:0] mem_data,
    output logic [8:0] data_ofs,
    output logic [7:0] cur_byte,
    output logic       busy
);
    rsp_desc_t  desc_q;
    logic [9:0] idx_q;
    logic       busy_q;

    assign busy     = busy_q;
    assign data_ofs = 9'(idx_q - 10'd4);

    always_comb begin
        if (!busy_q)                       cur_byte = FILL;
        else if (desc_q.kind == RK_BYTES)  cur_byte = (idx_q == 10'd0) ? desc_q.b0 : desc_q.b1;
        else if (idx_q == 10'd0)           cur_byte = desc_q.b0;
        else if (idx_q < 10'd3)            cur_byte = FILL;
        else if (idx_q == 10'd3)           cur_byte = TOK_START;
        else if (idx_q < DATA_END)         cur_byte = mem_data;
        else                               cur_byte = FILL;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            desc_q <= one_byte(FILL);
        end else if (load) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            desc_q <= desc;
        end else if (pop && busy_q) begin
            if (idx_q == desc_q.len - 10'd1) begin
                busy_q <= 1'b0;
                idx_q  <= '0;
            end else begin
                idx_q <= idx_q + 10'd1;
            end
        end
    end
endmodule

// File: rtl/sdr_block_store.sv
module sdr_block_store #(
    parameter int unsigned DEPTH = 2048,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sd_spi_responder.sv
module sd_spi_responder
    import sdr_pkg::*;
#(
    parameter int unsigned NUM_BLOCKS = 4,
    localparam int unsigned DEPTH     = NUM_BLOCKS * 512,
    localparam int unsigned AW        = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_wr,
    input  logic       sel_val,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_byte,
    input  logic       rsp_rd,
    output logic [7:0] rsp_byte
);
    localparam logic [32:0] CAP = 33'(DEPTH);

    logic        sel_n_q;
    ostate_t     ost_q;
    logic [2:0]  cnt_q;
    logic [5:0]  cidx_q;
    logic [31:0] arg_q;
    logic        end_q;
    logic        app_q;
    logic [31:0] rd_base_q, wr_base_q;
    logic        wr_ok_q;
    logic [9:0]  wofs_q;

    logic        wr_go, rd_go, flush, exec, commit, load, rsp_busy;
    logic        rd_fits, dec_set_app, mem_we;
    ostate_t     dec_nxt;
    rsp_desc_t   dec_desc, load_desc;
    logic [8:0]  data_ofs;
    logic [7:0]  mem_rdata, seq_byte;

    assign flush   = sel_wr && sel_val;
    assign wr_go   = cmd_wr && !sel_n_q;
    assign rd_go   = rsp_rd && !sel_n_q;
    assign rd_fits = blk_fits(arg_q, CAP);
    assign exec    = wr_go && (ost_q == OS_CMD) && (cnt_q == FRAME_LEN);
    assign commit  = wr_go && (ost_q == OS_WBLK) && (wofs_q == BLK_LEN);
    assign load    = exec || commit;
    assign load_desc = exec ? dec_desc : one_byte(wr_ok_q ? WR_ACCEPT : WR_REJECT);
    assign mem_we  = wr_go && (ost_q == OS_WBLK) && (wofs_q < BLK_LEN) && wr_ok_q;
    assign rsp_byte = sel_n_q ? FILL : seq_byte;

    sdr_cmd_decode u_dec (
        .op      ({app_q, cidx_q}),
        .end_bit (end_q),
        .rd_fits (rd_fits),
        .desc    (dec_desc),
        .nxt     (dec_nxt),
        .set_app (dec_set_app)
    );

    sdr_resp_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .load     (load),
        .desc     (load_desc),
        .pop      (rd_go),
        .mem_data (mem_rdata),
        .data_ofs (data_ofs),
        .cur_byte (seq_byte),
        .busy     (rsp_busy)
    );

    sdr_block_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (AW'(wr_base_q + 32'(wofs_q))),
        .wdata (cmd_byte),
        .raddr (AW'(rd_base_q + 32'(data_ofs))),
        .rdata (mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst)         sel_n_q <= 1'b1;
        else if (sel_wr) sel_n_q <= sel_val;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            ost_q     <= OS_IDLE;
            cnt_q     <= '0;
            cidx_q    <= '0;
            arg_q     <= '0;
            end_q     <= 1'b0;
            app_q     <= 1'b0;
            rd_base_q <= '0;
            wr_base_q <= '0;
            wr_ok_q   <= 1'b0;
            wofs_q    <= '0;
        end else if (wr_go) begin
            case (ost_q)
                OS_IDLE: begin
                    if (cmd_byte[7:6] == 2'b01) begin
                        cidx_q <= cmd_byte[5:0];
                        cnt_q  <= 3'd1;
                        ost_q  <= OS_CMD;
                    end
                end
                OS_CMD: begin
                    if (cnt_q < 3'd5) begin
                        arg_q <= {arg_q[23:0], cmd_byte};
                        cnt_q <= cnt_q + 3'd1;
                    end else if (cnt_q == 3'd5) begin
                        end_q <= cmd_byte[0];
                        cnt_q <= FRAME_LEN;
                    end else begin
                        ost_q     <= dec_nxt;
                        app_q     <= dec_set_app;
                        cnt_q     <= '0;
                        rd_base_q <= arg_q;
                        wr_base_q <= arg_q;
                        wr_ok_q   <= rd_fits;
                    end
                end
                OS_SBLK: begin
                    if (cmd_byte == TOK_START) begin
                        ost_q  <= OS_WBLK;
                        wofs_q <= '0;
                    end
                end
                OS_WBLK: begin
                    if (wofs_q < BLK_LEN) wofs_q <= wofs_q + 10'd1;
                    else                  ost_q  <= OS_IDLE;
                end
                default: ost_q <= OS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sdr_checker.sv
module sdr_checker
    import sdr_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       sel_wr,
    input logic       sel_val,
    input logic       cmd_wr,
    input logic [7:0] cmd_byte,
    input logic       rsp_rd,
    input logic [7:0] rsp_byte,
    input ostate_t    ostate,
    input logic       rsp_busy
);
    logic desel_m;

    always_ff @(posedge clk) begin
        if (rst)         desel_m <= 1'b1;
        else if (sel_wr) desel_m <= sel_val;
    end

    p_desel_ff_r1: assert property (@(posedge clk) disable iff (rst)
        desel_m |-> rsp_byte == 8'hFF);

    p_desel_nowrite_r1: assert property (@(posedge clk) disable iff (rst)
        (desel_m && cmd_wr && !sel_wr) |=> $stable(ostate));

    p_flush_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (sel_wr && sel_val) |=> (ostate == OS_IDLE && !rsp_busy));

    p_no_start_r3: assert property (@(posedge clk) disable iff (rst)
        (!desel_m && !sel_wr && cmd_wr && ostate == OS_IDLE && cmd_byte[7:6] != 2'b01)
        |=> ostate == OS_IDLE);

    p_wait_token_r9: assert property (@(posedge clk) disable iff (rst)
        (!desel_m && !sel_wr && cmd_wr && ostate == OS_SBLK && cmd_byte != 8'hFE)
        |=> ostate == OS_SBLK);

    p_drain_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(rsp_busy) |-> $past(rsp_rd || (sel_wr && sel_val)));
endmodule

bind sd_spi_responder sdr_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .sel_wr   (sel_wr),
    .sel_val  (sel_val),
    .cmd_wr   (cmd_wr),
    .cmd_byte (cmd_byte),
    .rsp_rd   (rsp_rd),
    .rsp_byte (rsp_byte),
    .ostate   (ost_q),
    .rsp_busy (rsp_busy)
);

// File: tb/tb_sd_spi_responder.sv
module tb_sd_spi_responder;
    localparam int DEPTH = 2048;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_wr = 1'b0, sel_val = 1'b1;
    logic       cmd_wr = 1'b0, rsp_rd = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic [7:0] rsp_byte;

    int checks = 0, errors = 0;
    logic [7:0] model [DEPTH];

    always #5 clk = ~clk;

    sd_spi_responder dut (
        .clk(clk), .rst(rst), .sel_wr(sel_wr), .sel_val(sel_val),
        .cmd_wr(cmd_wr), .cmd_byte(cmd_byte), .rsp_rd(rsp_rd), .rsp_byte(rsp_byte)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(logic [7:0] b);
        cmd_wr = 1'b1; cmd_byte = b;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic rd(output logic [7:0] v);
        v = rsp_byte; rsp_rd = 1'b1;
        @(negedge clk);
        rsp_rd = 1'b0;
    endtask

    task automatic expect_rd(string req, logic [7:0] exp);
        logic [7:0] v;
        rd(v);
        check(req, v, exp);
    endtask

    task automatic set_sel(logic v);
        sel_wr = 1'b1; sel_val = v;
        @(negedge clk);
        sel_wr = 1'b0;
    endtask

    task automatic frame(logic [5:0] idx, logic [31:0] arg, logic [7:0] last);
        wr({2'b01, idx});
        wr(arg[31:24]); wr(arg[23:16]); wr(arg[15:8]); wr(arg[7:0]);
        wr(last);
    endtask

    task automatic send_cmd(logic [5:0] idx, logic [31:0] arg, logic [7:0] last);
        frame(idx, arg, last);
        wr(8'hFF);
    endtask

    function automatic logic [7:0] pat(int a, int seed);
        return 8'((a * 7 + seed) ^ (a >> 5));
    endfunction

    task automatic write_block(logic [31:0] addr, int seed, bit ok);
        send_cmd(6'd24, addr, 8'h95);
        expect_rd("R9 write R1", 8'h00);
        wr(8'hFF); wr(8'h00); wr(8'h7E);
        wr(8'hFE);
        for (int i = 0; i < 512; i++) begin
            wr(pat(int'(addr) + i, seed));
            if (ok) model[int'(addr) + i] = pat(int'(addr) + i, seed);
        end
        wr(8'hFF);
        if (ok) expect_rd("R9 accept token", 8'h05);
        else    expect_rd("R10 reject token", 8'h0B);
        expect_rd("R11 idle after token", 8'hFF);
    endtask

    task automatic read_block(logic [31:0] addr, string req);
        send_cmd(6'd17, addr, 8'h95);
        expect_rd(req, 8'h00);
        expect_rd(req, 8'hFF);
        expect_rd(req, 8'hFF);
        expect_rd(req, 8'hFE);
        for (int i = 0; i < 512; i++) expect_rd(req, model[int'(addr) + i]);
        expect_rd(req, 8'hFF);
        expect_rd(req, 8'hFF);
        expect_rd("R11 idle after block", 8'hFF);
    endtask

    task automatic t_reset;
        check("R1 reset deselected", rsp_byte, 8'hFF);
        set_sel(1'b0);
        check("R11 idle select", rsp_byte, 8'hFF);
    endtask

    task automatic t_deselect;
        set_sel(1'b1);
        send_cmd(6'd0, 32'h0, 8'h95);
        check("R1 ignored while deselected", rsp_byte, 8'hFF);
        set_sel(1'b0);
        expect_rd("R1 no response from ignored frame", 8'hFF);
        send_cmd(6'd13, 32'h0, 8'h95);
        set_sel(1'b1);
        expect_rd("R1 read while deselected", 8'hFF);
        set_sel(1'b0);
        expect_rd("R2 response flushed", 8'hFF);
        wr(8'h40); wr(8'h00); wr(8'h00);
        set_sel(1'b1); set_sel(1'b0);
        send_cmd(6'd0, 32'h0, 8'h95);
        expect_rd("R2 partial frame dropped", 8'h01);
        send_cmd(6'd55, 32'h0, 8'h95);
        expect_rd("R5 prefix", 8'h01);
        set_sel(1'b1); set_sel(1'b0);
        send_cmd(6'd41, 32'h0, 8'h95);
        expect_rd("R2 app flag cleared", 8'h04);
    endtask

    task automatic t_framing;
        wr(8'h00); wr(8'hFF); wr(8'h80);
        expect_rd("R3 non-start bytes", 8'hFF);
        frame(6'd0, 32'h0, 8'h95);
        expect_rd("R3 no answer before trigger", 8'hFF);
        wr(8'h40);
        expect_rd("R3 trigger executes", 8'h01);
        expect_rd("R11 drained", 8'hFF);
    endtask

    task automatic t_basic;
        send_cmd(6'd8, 32'h1AA, 8'h87);
        expect_rd("R6 cmd8", 8'h04);
        send_cmd(6'd13, 32'h0, 8'h95);
        expect_rd("R6 cmd13 first", 8'h00);
        expect_rd("R6 cmd13 second", 8'h00);
        expect_rd("R11 after cmd13", 8'hFF);
        send_cmd(6'd5, 32'h0, 8'h95);
        expect_rd("R6 other index", 8'h04);
        send_cmd(6'd0, 32'h0, 8'h94);
        expect_rd("R4 end bit clear", 8'h05);
        send_cmd(6'd8, 32'h0, 8'h94);
        expect_rd("R4 cmd8 end bit clear", 8'h04);
        send_cmd(6'd0, 32'h0, 8'h95);
        send_cmd(6'd13, 32'h0, 8'h95);
        expect_rd("R6 newer response replaces", 8'h00);
    endtask

    task automatic t_app;
        send_cmd(6'd55, 32'h0, 8'h95);
        expect_rd("R5 cmd55", 8'h01);
        send_cmd(6'd41, 32'h4000_0000, 8'h95);
        expect_rd("R5 acmd41", 8'h00);
        send_cmd(6'd41, 32'h0, 8'h95);
        expect_rd("R5 flag consumed", 8'h04);
        send_cmd(6'd55, 32'h0, 8'h95);
        expect_rd("R5 cmd55 again", 8'h01);
        send_cmd(6'd55, 32'h0, 8'h95);
        expect_rd("R5 app 55 illegal", 8'h04);
        send_cmd(6'd55, 32'h0, 8'h95);
        expect_rd("R5 cmd55 third", 8'h01);
        send_cmd(6'd17, 32'h0, 8'h95);
        expect_rd("R5 app 17 illegal", 8'h04);
        expect_rd("R5 app 17 single byte", 8'hFF);
    endtask

    task automatic t_data;
        for (int b = 0; b < 4; b++) write_block(32'(b * 512), 11 + b, 1'b1);
        read_block(32'd0, "R7 aligned read");
        read_block(32'd5, "R7 unaligned read");
        read_block(32'd1000, "R7 cross block read");
    endtask

    task automatic t_bounds;
        read_block(32'd1536, "R8 last block in range");
        send_cmd(6'd17, 32'd1537, 8'h95);
        expect_rd("R8 past end", 8'h04);
        expect_rd("R8 single byte", 8'hFF);
        send_cmd(6'd17, 32'hFFFF_FE00, 8'h95);
        expect_rd("R8 no wrap", 8'h04);
        write_block(32'd1537, 99, 1'b0);
        read_block(32'd1536, "R10 store unchanged");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 00 expected 01");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_deselect();
        t_framing();
        t_basic();
        t_app();
        t_data();
        t_bounds();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule